// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block is a single-channel pulse-width modulator controlled through a small word-wide register bus. Software programs a period, picks a tick source and a prescaler, and then pushes duty values into a four-entry sample queue. Each output period starts high. The output falls when the period counter reaches the active duty value and stays low until the counter rolls over. After a duty value has been used for its programmed number of periods, the next queued value replaces it at a rollover. When the queue is empty, the active value is kept.

The three tick sources are plain single-cycle enable inputs that are synchronous to `clk`. The control register also holds an output polarity mode and a self-clearing reset command. The status register reports the queue level together with four sticky event flags, each cleared by writing 1 to its bit. Reads have no side effects and `reg_rdata` follows `reg_addr` combinationally.

Top module: `fifo_pwm`

## Requirements
- R1: In normal mode, with a period register value P (below 0xFFFF) and an active duty value S, each period lasts P+2 prescaled steps and the output is high for the first min(S, P+2) of them. The first period begins on the clock edge that writes enable (control bit 0) from 0 to 1.
- R2: A period register value of 0xFFFF gives the same period as 0xFFFE, which is 65536 steps. The register reads back the value written.
- R3: Control bits [15:4] hold the divider minus one. A field value of n makes each step last n+1 selected ticks.
- R4: Control bits [17:16] select the tick source: 0 selects none (the counter freezes), 1 selects `tick_bus`, 2 selects `tick_fast` and 3 selects `tick_slow`.
- R5: Control bits [19:18] set the output mode: 0 is normal, 1 is inverted (the output is low for min(S, P+2) steps and then high), and 2 or 3 gives a constant 0. In every mode the output is 0 while enable is clear.
- R6: Writes to offset 0x0C enter a queue of depth 4 and are consumed in write order. A write of enable from 0 to 1 loads the oldest entry as the active value. Status bits [2:0] give the level. A write to a full queue is dropped and sets status bit 6.
- R7: Control bits [2:1] select reuse: 0, 1, 2 and 3 use each sample for 1, 2, 4 and 8 periods. The next entry is taken at the rollover that ends the last use. If the queue is empty, the active value continues.
- R8: Status bit 3 (queue empty) is set at reset, at a flush, and when taking an entry leaves the queue empty. Bit 4 is set at every rollover. Bit 5 is set on a step taken while the counter equals the active value. Bits 3 to 6 hold until software writes 1 to them.
- R9: A read of offset 0x0C returns the active duty value while enabled, and 0 otherwise.
- R10: Writing 1 to control bit 3 returns the whole block to its reset state. Control bit 3 then reads 1 for RST_CYC cycles and clears itself. Register writes made during that time are ignored.
- R11: A write that clears enable empties the queue and restarts the counter, the prescaler and the reuse count. The next enable starts a fresh period.
- R12: After reset, control, sample and period read 0, status reads 0x08, and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_bus | input | 1 | Tick enable, source 1 |
| tick_fast | input | 1 | Tick enable, source 2 |
| tick_slow | input | 1 | Tick enable, source 3 |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset: 0x00 control, 0x04 status, 0x0C sample, 0x10 period |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that each register write lasts exactly one cycle. They also assume that the tick inputs are synchronous enables and never asynchronous clocks. The stimulus drives every input at the falling edge and issues whole-word writes through one write task that holds `reg_we` for a single cycle. It holds the tick inputs steady through each measurement window and changes them only between windows. It never rewrites the period while the counter runs, so the flush and reset properties see only the write patterns the block is specified for.

// File: rtl/fifo_pwm.sv
module fifo_pwm #(
  parameter int SW      = 16,
  parameter int FAW     = 2,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_bus,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pwm_out
);
  localparam int DW    = 12;
  localparam int DEPTH = 1 << FAW;
  localparam int CW    = FAW + 1;
  localparam int RCW   = $clog2(RST_CYC + 1);
  localparam logic [SW-1:0] ONE = 1;

  logic          en;
  logic [1:0]    rpt, src, omode;
  logic [DW-1:0] div, pre;
  logic [SW-1:0] per, cur, ctr;
  logic [2:0]    rep;
  logic [SW-1:0] mem [DEPTH];
  logic [FAW-1:0] wp, rp;
  logic [CW-1:0] lvl;
  logic          fe, rov, cmp, fwe;
  logic [RCW-1:0] rst_left;

  wire busy   = rst_left != '0;
  wire wr_ok  = reg_we && !busy;
  wire wr_ctl = wr_ok && reg_addr == 5'h00;
  wire wr_sts = wr_ok && reg_addr == 5'h04;
  wire wr_smp = wr_ok && reg_addr == 5'h0C;
  wire wr_per = wr_ok && reg_addr == 5'h10;
  wire swr    = wr_ctl && reg_wdata[3];
  wire en_on  = wr_ctl && !swr && reg_wdata[0] && !en;
  wire en_off = wr_ctl && !swr && !reg_wdata[0] && en;
  wire full   = lvl == CW'(DEPTH);

  wire tick = (src == 2'd1) ? tick_bus :
              (src == 2'd2) ? tick_fast :
              (src == 2'd3) ? tick_slow : 1'b0;
  wire adv  = en && tick && !en_off;
  wire step = adv && pre == div;

  wire [SW-1:0] top = ((&per) ? per - ONE : per) + ONE;
  wire roll = step && ctr >= top;

  wire [2:0] rep_max  = 3'((1 << rpt) - 1);
  wire       last_use = rep == rep_max;
  wire pop  = (en_on || (roll && last_use)) && lvl != '0;
  wire push = wr_smp && !full;

  always_ff @(posedge clk)
    if (push) mem[wp] <= reg_wdata[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rpt <= '0; src <= '0; omode <= '0; div <= '0; per <= '0;
      cur <= '0; ctr <= '0; pre <= '0; rep <= '0;
      wp <= '0; rp <= '0; lvl <= '0;
      fe <= 1'b1; rov <= 1'b0; cmp <= 1'b0; fwe <= 1'b0;
      rst_left <= '0;
    end else if (swr) begin
      en <= 1'b0; rpt <= '0; src <= '0; omode <= '0; div <= '0; per <= '0;
      cur <= '0; ctr <= '0; pre <= '0; rep <= '0;
      wp <= '0; rp <= '0; lvl <= '0;
      fe <= 1'b1; rov <= 1'b0; cmp <= 1'b0; fwe <= 1'b0;
      rst_left <= RCW'(RST_CYC);
    end else begin
      if (busy) rst_left <= rst_left - RCW'(1);

      if (wr_ctl) begin
        en    <= reg_wdata[0];
        rpt   <= reg_wdata[2:1];
        div   <= reg_wdata[15:4];
        src   <= reg_wdata[17:16];
        omode <= reg_wdata[19:18];
      end
      if (wr_per) per <= reg_wdata[SW-1:0];

      if (en_on || en_off) begin
        ctr <= '0; pre <= '0; rep <= '0;
        cur <= pop ? mem[rp] : '0;
      end else if (step) begin
        pre <= '0;
        ctr <= roll ? '0 : ctr + ONE;
        if (roll) rep <= last_use ? 3'd0 : rep + 3'd1;
        if (pop) cur <= mem[rp];
      end else if (adv) begin
        pre <= pre + DW'(1);
      end

      if (en_off) begin
        wp <= '0; rp <= '0; lvl <= '0;
      end else begin
        if (push) wp <= wp + FAW'(1);
        if (pop)  rp <= rp + FAW'(1);
        lvl <= lvl + CW'(push) - CW'(pop);
      end

      fe  <= (fe  & ~(wr_sts & reg_wdata[3])) | en_off | (pop && lvl == CW'(1) && !push);
      rov <= (rov & ~(wr_sts & reg_wdata[4])) | roll;
      cmp <= (cmp & ~(wr_sts & reg_wdata[5])) | (step && ctr == cur);
      fwe <= (fwe & ~(wr_sts & reg_wdata[6])) | (wr_smp && full);
    end
  end

  wire hi = en && ctr < cur;
  assign pwm_out = (omode == 2'd0) ? hi :
                   (omode == 2'd1) ? (en && !hi) : 1'b0;

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = {12'd0, omode, src, div, busy, rpt, en};
      5'h04:   reg_rdata = {25'd0, fwe, cmp, rov, fe, 3'(lvl)};
      5'h0C:   reg_rdata = en ? 32'(cur) : 32'd0;
      5'h10:   reg_rdata = 32'(per);
      default: reg_rdata = 32'd0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:20];
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk #(
  parameter int SW    = 16,
  parameter int CW    = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic          wd_en,
  input logic          wd_rst,
  input logic          pwm_out,
  input logic          en,
  input logic          busy,
  input logic [CW-1:0] lvl,
  input logic [SW-1:0] ctr,
  input logic [1:0]    omode,
  input logic          fwe
);
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= CW'(DEPTH));

  a_r6_full_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == 5'h0C && lvl == CW'(DEPTH)) |=> fwe);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  a_r5_disconnected_low: assert property (@(posedge clk) disable iff (!rst_n)
    omode[1] |-> !pwm_out);

  a_r10_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == 5'h00 && wd_rst) |=> (busy && !en && lvl == '0));

  a_r10_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !en);

  a_r11_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == 5'h00 && !wd_rst && !wd_en && en) |=> (lvl == '0 && ctr == '0));
endmodule

bind fifo_pwm fifo_pwm_chk #(.SW(SW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_en(reg_wdata[0]), .wd_rst(reg_wdata[3]), .pwm_out(pwm_out),
  .en(en), .busy(busy), .lvl(lvl), .ctr(ctr), .omode(omode), .fwe(fwe)
);

// File: tb/fifo_pwm_test.sv
`timescale 1ns/1ps
module fifo_pwm_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_bus = 1'b1, tick_fast = 1'b1, tick_slow = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = 5'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic pwm_out;
  logic [31:0] v;
  int nchk = 0, nfail = 0, h;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_pwm uut (
    .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] r);
    reg_addr = a;
    #1;
    r = reg_rdata;
  endtask

  task automatic count_high(int n, output int hc);
    hc = 0;
    for (int i = 0; i < n; i++) begin
      hc += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cv(int e, int r, int dv, int s, int m);
    return 32'(e) | (32'(r) << 1) | (32'(dv - 1) << 4) | (32'(s) << 16) | (32'(m) << 18);
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic clean();
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h0);
  endtask

  task automatic run_case(int p, int s, int dv, int srcsel, int mode, string req);
    int L, e;
    clean();
    wr(5'h10, 32'(p));
    wr(5'h0C, 32'(s));
    wr(5'h00, cv(1, 0, dv, srcsel, mode));
    L = p + 2;
    e = (mode == 0) ? dv * imin(s, L) : (mode == 1) ? dv * (L - imin(s, L)) : 0;
    count_high(L * dv, h);
    check(req, h, e);
    count_high(L * dv, h);
    check(req, h, e);
    rd(5'h0C, v);
    check("R9 sample read while enabled", v, s);
  endtask

  task automatic rep_case(int r, int p, int a, int b);
    int n, L;
    clean();
    wr(5'h04, 32'h08);
    wr(5'h10, 32'(p));
    wr(5'h0C, 32'(a));
    wr(5'h0C, 32'(b));
    wr(5'h00, cv(1, r, 1, 1, 0));
    rd(5'h04, v);
    check("R6 level after enable", v & 32'h7, 1);
    n = 1 << r;
    L = p + 2;
    count_high(n * L, h);
    check("R7 first sample reuse", h, n * imin(a, L));
    count_high(L, h);
    check("R7 second sample taken", h, imin(b, L));
    count_high(n * L, h);
    check("R7 last sample kept when empty", h, n * imin(b, L));
    rd(5'h04, v);
    check("R8 empty flag after last take", v & 32'hF, 32'h8);
  endtask

  initial begin
    #(190000 * 5.0);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(5'h00, v); check("R12 control", v, 0);
    rd(5'h04, v); check("R12 status", v, 32'h08);
    rd(5'h0C, v); check("R12 sample", v, 0);
    rd(5'h10, v); check("R12 period", v, 0);
    check("R12 output", pwm_out, 0);

    // R1 and R5 sweep
    for (int p = 0; p < 4; p++)
      for (int s = 0; s <= p + 3; s++) begin
        run_case(p, s, 1, 1, 0, "R1 normal high time");
        run_case(p, s, 1, 1, 1, "R5 inverted high time");
      end
    for (int s = 0; s < 4; s++) begin
      run_case(2, s, 1, 1, 2, "R5 disconnected mode 2");
      run_case(2, s, 1, 1, 3, "R5 disconnected mode 3");
    end

    // R3 prescaler sweep
    for (int dv = 2; dv <= 4; dv++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s <= p + 2; s++)
          run_case(p, s, dv, 1, 0, "R3 prescaled high time");

    // R4 tick source selection
    clean();
    wr(5'h10, 32'd2);
    wr(5'h0C, 32'd1);
    wr(5'h04, 32'h30);
    wr(5'h00, cv(1, 0, 1, 0, 0));
    count_high(8, h);
    check("R4 source off freezes", h, 8);
    rd(5'h04, v); check("R4 no rollover with source off", (v >> 4) & 1, 0);
    wr(5'h00, cv(1, 0, 1, 3, 0));
    count_high(8, h);
    check("R4 slow source idle freezes", h, 8);
    tick_slow = 1'b1;
    count_high(4, h);
    check("R4 slow source runs", h, 1);
    rd(5'h04, v); check("R4 rollover on slow source", (v >> 4) & 1, 1);
    tick_slow = 1'b0;
    tick_bus = 1'b0;
    run_case(2, 3, 1, 2, 0, "R4 fast source");
    tick_bus = 1'b1;

    // R7 reuse counts
    rep_case(0, 1, 1, 3);
    rep_case(1, 4, 1, 3);
    rep_case(2, 1, 1, 2);
    rep_case(3, 0, 2, 0);

    // R6 overflow and order
    clean();
    wr(5'h04, 32'h40);
    wr(5'h10, 32'd8);
    wr(5'h0C, 32'd1);
    wr(5'h0C, 32'd2);
    wr(5'h0C, 32'd3);
    wr(5'h0C, 32'd4);
    wr(5'h0C, 32'd9);
    rd(5'h04, v); check("R6 full level and write error", v & 32'h47, 32'h44);
    wr(5'h04, 32'h40);
    rd(5'h04, v); check("R8 write error cleared by 1", v & 32'h40, 0);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    for (int k = 1; k <= 5; k++) begin
      count_high(10, h);
      check("R6 write order, overflow dropped", h, (k < 5) ? k : 4);
    end
    rd(5'h0C, v); check("R9 active sample", v, 4);
    wr(5'h00, 32'h0);
    rd(5'h0C, v); check("R9 sample reads 0 when disabled", v, 0);

    // R8 compare flag
    clean();
    wr(5'h04, 32'h78);
    wr(5'h10, 32'd3);
    wr(5'h0C, 32'd7);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    count_high(10, h);
    rd(5'h04, v);
    check("R8 no compare when sample beyond period", (v >> 5) & 1, 0);
    check("R8 rollover flag", (v >> 4) & 1, 1);
    clean();
    wr(5'h04, 32'h78);
    wr(5'h0C, 32'd2);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    count_high(5, h);
    rd(5'h04, v); check("R8 compare flag", (v >> 5) & 1, 1);

    // R11 disable flush and restart
    clean();
    wr(5'h10, 32'd5);
    wr(5'h0C, 32'd4);
    wr(5'h0C, 32'd6);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    count_high(3, h);
    wr(5'h00, 32'h0);
    rd(5'h04, v); check("R11 queue flushed", v & 32'hF, 32'h8);
    wr(5'h0C, 32'd2);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    count_high(7, h);
    check("R11 fresh period after restart", h, 2);

    // R2 clamp of 0xFFFF
    clean();
    wr(5'h10, 32'hFFFF);
    rd(5'h10, v); check("R2 period readback", v, 32'hFFFF);
    wr(5'h0C, 32'd0);
    wr(5'h04, 32'h10);
    wr(5'h00, cv(1, 0, 1, 1, 0));
    repeat (65535) @(negedge clk);
    rd(5'h04, v); check("R2 no rollover before 65536 steps", (v >> 4) & 1, 0);
    @(negedge clk);
    rd(5'h04, v); check("R2 rollover at 65536 steps", (v >> 4) & 1, 1);

    // R10 software reset
    clean();
    wr(5'h10, 32'd5);
    wr(5'h0C, 32'd3);
    wr(5'h00, cv(1, 1, 2, 1, 1));
    wr(5'h00, 32'h8);
    rd(5'h00, v); check("R10 reset bit reads 1", v, 32'h8);
    wr(5'h10, 32'd7);
    repeat (3) @(negedge clk);
    rd(5'h00, v); check("R10 reset bit self clears", v, 0);
    rd(5'h10, v); check("R10 write during reset ignored", v, 0);
    rd(5'h04, v); check("R10 status at reset value", v, 32'h08);
    check("R10 output idle", pwm_out, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule